// File: doc/BRIEF.md
# Host Wake and Access Handshake

This block decides when a host may safely touch device-internal resources that can lose power. The host drives two control bits through a small register write port: an init bit that asks for the fully operational power state, and an access-request bit that asks the device to stay awake. A power manager inside the chip asks for sleep through a single request line. The block runs a five-state power sequence (off, waking, awake, going to sleep, asleep). It reports clock-ready, going-to-sleep and an encoded power-save mode back through the readable control word.

A downstream bus gate uses the `access_ok` output. It is high only while the clock is ready, no sleep entry is under way, and the host is holding its access request. A second register provides a self-clearing software reset, which drops the host control bits and forces the sequence back to off. The same register holds a bus-master stop request, and a master-disabled flag follows that request one cycle later. The wake delay and the sleep-entry duration are parameters that stand in for clock settling time.

Top module: `host_wake_ctl`

## Requirements
- R1: Once synchronous reset is released, `clock_ready`, `going_to_sleep` and `access_ok` are 0 and `pwr_mode` is 001. `ctrl_rdata` reads 0x0100_0000, which is mode 001 in bits 26:24 with the RF-kill bit 27 low. `rst_rdata` reads 0.
- R2: `clock_ready` never rises unless the init bit (control bit 2) was set in the cycle before. Setting only access-request (control bit 3) leaves `clock_ready` at 0.
- R3: Suppose a control write that sets the init bit is accepted at clock edge E. The sequence enters waking at edge E+1, with `pwr_mode` 000 and `clock_ready` 0. `clock_ready` reads 1 after edge E+1+WAKE_CYC, and stays 0 before that edge.
- R4: While access-request is held and the state is awake, a sleep request on `pm_sleep_req` is refused. `clock_ready` stays 1 and `going_to_sleep` stays 0.
- R5: Consider the awake state with access-request low, the init bit high and `pm_sleep_req` high. `going_to_sleep` (control bit 4) rises after the next edge and stays high for exactly SLEEP_CYC cycles, with `clock_ready` still 1. After that, `clock_ready` and `going_to_sleep` are 0 and `pwr_mode` is 001.
- R6: `access_ok` is 1 exactly when clock-ready is 1, going-to-sleep is 0 and access-request is 1.
- R7: In the asleep state, the sequence returns to waking on the next edge if either of two things holds: access-request is high, or `pm_sleep_req` is low. It then becomes ready after WAKE_CYC more cycles.
- R8: If the init bit reads 0, `clock_ready` is 0 in the following cycle, and `pwr_mode` reads 001 once the state is off.
- R9: Writing 1 to bit 7 of the reset register (`wr_sel`=1) clears init, access-request and crystal-on (control bit 10) and forces the state off at that edge. Bit 7 always reads 0.
- R10: Bit 9 of the reset register stores the bus-master stop request. Bit 8 (master-disabled) reads the value bit 9 had one cycle earlier.
- R11: The control word carries these fields. Bit 0 is clock-ready, bit 2 is init, bit 3 is access-request, bit 4 is going-to-sleep and bit 10 is crystal-on. Bits 26:24 hold the mode and bit 27 mirrors `rf_kill_sw`. The mode is 010 when clock-ready and `rf_kill_sw` are both 1. It is 001 in the off and asleep states. In every other case it is 000, and 011 is never produced.
- R12: Control writes affect only bits 2, 3 and 10. For example, writing 0xFFFF_FFFF while awake with RF-kill low reads back 0x0000_040D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 reset register |
| wr_data | input | 32 | Write data |
| pm_sleep_req | input | 1 | Sleep request from the internal power manager |
| rf_kill_sw | input | 1 | Hardware RF-kill switch level |
| ctrl_rdata | output | 32 | Control word readback |
| rst_rdata | output | 32 | Reset register readback |
| clock_ready | output | 1 | Internal clock ready, resources reachable |
| going_to_sleep | output | 1 | Sleep entry under way |
| access_ok | output | 1 | Host access granted to the bus gate |
| pwr_mode | output | 3 | Encoded power-save mode |

## Verification
Every status output is decoded from the registered state, so a wrong state shows at the ports in the cycle right after the faulty transition. A miscounted wake or sleep delay moves the edge of `clock_ready` or `going_to_sleep` by one or more cycles. The bench samples these edges at the exact cycle the requirements give. A refused sleep that the block wrongly honours drops `clock_ready` within one cycle. A missed software reset leaves the control bits visible on the next readback.

// File: rtl/hwk_pkg.sv
// Package: shared state type, register bit positions and mode codes
// for the host wake and access handshake.
package hwk_pkg;
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_WAKING   = 3'd1,
        ST_AWAKE    = 3'd2,
        ST_GO_SLEEP = 3'd3,
        ST_ASLEEP   = 3'd4
    } pwr_state_e;

    localparam int CTL_READY   = 0;
    localparam int CTL_INIT    = 2;
    localparam int CTL_REQ     = 3;
    localparam int CTL_GTS     = 4;
    localparam int CTL_XTAL    = 10;
    localparam int CTL_MODE_LO = 24;
    localparam int CTL_RFKILL  = 27;

    localparam int RST_SOFT = 7;
    localparam int RST_MDIS = 8;
    localparam int RST_STOP = 9;

    localparam logic [2:0] MODE_NONE       = 3'b000;
    localparam logic [2:0] MODE_MAC_DOWN   = 3'b001;
    localparam logic [2:0] MODE_RADIO_DOWN = 3'b010;
endpackage

// File: rtl/hwk_csr.sv
// Module: hwk_csr
// Holds the host-writable control bits and the reset register bits.
// Assumes one write per cycle; a soft reset write clears the control
// bits but still loads the bus-master stop bit from the same write.
module hwk_csr
    import hwk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          init_done,
    output logic          access_req,
    output logic          xtal_on,
    output logic          stop_master,
    output logic          master_dis,
    output logic          soft_rst
);
    logic unused_wr;

    // Bits of the write word that no field takes.
    assign unused_wr = ^wr_data;

    // Self-clearing software reset strobe.
    assign soft_rst = wr_en & wr_sel & wr_data[RST_SOFT];

    // Control bits: cleared by reset or soft reset, loaded by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            init_done  <= 1'b0;
            access_req <= 1'b0;
            xtal_on    <= 1'b0;
        end else if (wr_en && !wr_sel) begin
            init_done  <= wr_data[CTL_INIT];
            access_req <= wr_data[CTL_REQ];
            xtal_on    <= wr_data[CTL_XTAL];
        end
    end

    // Bus-master stop request and its delayed disabled flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_master <= 1'b0;
            master_dis  <= 1'b0;
        end else begin
            if (wr_en && wr_sel) stop_master <= wr_data[RST_STOP];
            master_dis <= stop_master;
        end
    end
endmodule

// File: rtl/hwk_fsm.sv
// Module: hwk_fsm
// Power sequence: off, waking (WAKE_CYC cycles), awake, going to sleep
// (SLEEP_CYC cycles), asleep. Losing the init bit returns to off from
// any state. Assumes both delays are at least one cycle.
module hwk_fsm
    import hwk_pkg::*;
#(
    parameter int WAKE_CYC  = 4,
    parameter int SLEEP_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       init_done,
    input  logic       access_req,
    input  logic       sleep_req,
    output pwr_state_e state
);
    localparam int MAXC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAKE_LOAD  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] SLEEP_LOAD = CW'(SLEEP_CYC - 1);

    pwr_state_e    nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // Next-state and delay counter selection.
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (!init_done) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt     = ST_WAKING;
                    cnt_nxt = WAKE_LOAD;
                end
                ST_WAKING: begin
                    if (cnt == '0) nxt = ST_AWAKE;
                    else           cnt_nxt = cnt - 1'b1;
                end
                ST_AWAKE: begin
                    if (sleep_req && !access_req) begin
                        nxt     = ST_GO_SLEEP;
                        cnt_nxt = SLEEP_LOAD;
                    end
                end
                ST_GO_SLEEP: begin
                    if (cnt == '0) nxt = ST_ASLEEP;
                    else           cnt_nxt = cnt - 1'b1;
                end
                ST_ASLEEP: begin
                    if (access_req || !sleep_req) begin
                        nxt     = ST_WAKING;
                        cnt_nxt = WAKE_LOAD;
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end
endmodule

// File: rtl/hwk_status.sv
// Module: hwk_status
// Decodes the power state into status flags, the mode code and the two
// readback words. Purely combinational; assumes registered inputs.
module hwk_status
    import hwk_pkg::*;
#(
    parameter int DW = 32
) (
    input  pwr_state_e    state,
    input  logic          rf_kill,
    input  logic          init_done,
    input  logic          access_req,
    input  logic          xtal_on,
    input  logic          stop_master,
    input  logic          master_dis,
    output logic          clock_ready,
    output logic          going_to_sleep,
    output logic          access_ok,
    output logic [2:0]    pwr_mode,
    output logic [DW-1:0] ctrl_rdata,
    output logic [DW-1:0] rst_rdata
);
    // Status flags and the power-save mode code.
    always_comb begin
        clock_ready    = (state == ST_AWAKE) || (state == ST_GO_SLEEP);
        going_to_sleep = (state == ST_GO_SLEEP);
        access_ok      = clock_ready && !going_to_sleep && access_req;
        if (clock_ready && rf_kill)                         pwr_mode = MODE_RADIO_DOWN;
        else if (state == ST_OFF || state == ST_ASLEEP)     pwr_mode = MODE_MAC_DOWN;
        else                                                pwr_mode = MODE_NONE;
    end

    // Readback word assembly.
    always_comb begin
        ctrl_rdata                     = '0;
        ctrl_rdata[CTL_READY]          = clock_ready;
        ctrl_rdata[CTL_INIT]           = init_done;
        ctrl_rdata[CTL_REQ]            = access_req;
        ctrl_rdata[CTL_GTS]            = going_to_sleep;
        ctrl_rdata[CTL_XTAL]           = xtal_on;
        ctrl_rdata[CTL_MODE_LO +: 3]   = pwr_mode;
        ctrl_rdata[CTL_RFKILL]         = rf_kill;
        rst_rdata                      = '0;
        rst_rdata[RST_MDIS]            = master_dis;
        rst_rdata[RST_STOP]            = stop_master;
    end
endmodule

// File: rtl/host_wake_ctl.sv
// Module: host_wake_ctl
// Top of the host wake and access handshake: register file, power
// sequence and status decode. Assumes rst_n is synchronous to clk.
module host_wake_ctl
    import hwk_pkg::*;
#(
    parameter int DW        = 32,
    parameter int WAKE_CYC  = 4,
    parameter int SLEEP_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          pm_sleep_req,
    input  logic          rf_kill_sw,
    output logic [DW-1:0] ctrl_rdata,
    output logic [DW-1:0] rst_rdata,
    output logic          clock_ready,
    output logic          going_to_sleep,
    output logic          access_ok,
    output logic [2:0]    pwr_mode
);
    logic       init_done, access_req, xtal_on, stop_master, master_dis, soft_rst;
    pwr_state_e state;

    hwk_csr #(.DW(DW)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .init_done(init_done), .access_req(access_req), .xtal_on(xtal_on),
        .stop_master(stop_master), .master_dis(master_dis), .soft_rst(soft_rst)
    );

    hwk_fsm #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .init_done(init_done),
        .access_req(access_req), .sleep_req(pm_sleep_req), .state(state)
    );

    hwk_status #(.DW(DW)) u_status (
        .state(state), .rf_kill(rf_kill_sw), .init_done(init_done),
        .access_req(access_req), .xtal_on(xtal_on), .stop_master(stop_master),
        .master_dis(master_dis), .clock_ready(clock_ready),
        .going_to_sleep(going_to_sleep), .access_ok(access_ok),
        .pwr_mode(pwr_mode), .ctrl_rdata(ctrl_rdata), .rst_rdata(rst_rdata)
    );
endmodule

// File: rtl/hwk_chk.sv
// Module: hwk_chk
// Port-level temporal checks for host_wake_ctl, attached by bind.
module hwk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_wr,
    input logic        sleep_req,
    input logic        rf_kill,
    input logic [31:0] ctrl_rdata,
    input logic [31:0] rst_rdata,
    input logic        clock_ready,
    input logic        going_to_sleep,
    input logic        access_ok,
    input logic [2:0]  pwr_mode
);
    AST_READY_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clock_ready) |-> $past(ctrl_rdata[2])); // R2

    AST_SLEEP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (clock_ready && !going_to_sleep && ctrl_rdata[3] && ctrl_rdata[2] && sleep_req && !soft_wr)
        |=> (clock_ready && !going_to_sleep)); // R4

    AST_SLEEP_EXIT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(going_to_sleep) |-> !clock_ready); // R5

    AST_OK_IMPLIES_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> (ctrl_rdata[0] && !ctrl_rdata[4] && ctrl_rdata[3])); // R6

    AST_SAFE_IMPLIES_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[0] && !ctrl_rdata[4] && ctrl_rdata[3]) |-> access_ok); // R6

    AST_NO_INIT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[2] |=> !clock_ready); // R8

    AST_SOFT_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_rdata[7]); // R9

    AST_MDIS_FOLLOWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rdata[9] |=> rst_rdata[8]); // R10

    AST_MDIS_FOLLOWS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_rdata[9] |=> !rst_rdata[8]); // R10

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != 3'b011); // R11

    AST_RADIO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (clock_ready && rf_kill) |-> (pwr_mode == 3'b010)); // R11
endmodule

bind host_wake_ctl hwk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_wr(wr_en & wr_sel & wr_data[7]),
    .sleep_req(pm_sleep_req), .rf_kill(rf_kill_sw), .ctrl_rdata(ctrl_rdata),
    .rst_rdata(rst_rdata), .clock_ready(clock_ready),
    .going_to_sleep(going_to_sleep), .access_ok(access_ok), .pwr_mode(pwr_mode)
);

// File: tb/sim_host_wake_ctl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected items stamped with the
// cycle they must appear in; the monitor compares them at the falling edge.
module sim_host_wake_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pm_sleep_req = 1'b0, rf_kill_sw = 1'b0;
    logic [31:0] ctrl_rdata, rst_rdata;
    logic        clock_ready, going_to_sleep, access_ok;
    logic [2:0]  pwr_mode;

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] mask;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    host_wake_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pm_sleep_req(pm_sleep_req), .rf_kill_sw(rf_kill_sw),
        .ctrl_rdata(ctrl_rdata), .rst_rdata(rst_rdata), .clock_ready(clock_ready),
        .going_to_sleep(going_to_sleep), .access_ok(access_ok), .pwr_mode(pwr_mode)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                logic [31:0] obs;
                case (q[i].sel)
                    0:       obs = ctrl_rdata;
                    1:       obs = rst_rdata;
                    default: obs = {26'd0, access_ok, going_to_sleep, clock_ready, pwr_mode};
                endcase
                compared++;
                if ((obs & q[i].mask) != q[i].val) begin
                    mismatched++;
                    $display("FAIL %s cyc %0d sel %0d: actual %h expected %h", q[i].tag,
                             cyc, q[i].sel, obs & q[i].mask, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic expect_at(int d, int sel, logic [31:0] mask, logic [31:0] val, string tag);
        item_t it;
        it.cyc = cyc + d; it.sel = sel; it.mask = mask; it.val = val; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write(logic sel, logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step(1);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog R1: actual hung expected finished");
            summary();
            $finish;
        end
    end

    // Driver.
    initial begin
        step(3);
        rst_n = 1'b1;
        // status vector: [5] ok, [4] gts, [3] ready, [2:0] mode
        expect_at(1, 2, 32'h3F, 32'h01, "R1 status");
        expect_at(1, 0, 32'hFFFF_FFFF, 32'h0100_0000, "R1 ctrl");
        expect_at(1, 1, 32'hFFFF_FFFF, 32'h0, "R1 rst");
        step(2);

        write(1'b0, 32'h8);
        for (int d = 1; d <= 8; d++) expect_at(d, 0, 32'h1, 32'h0, "R2 ready without init");
        step(9);

        write(1'b0, 32'hC);
        expect_at(2, 2, 32'h0F, 32'h00, "R3 waking mode");
        expect_at(4, 2, 32'h08, 32'h00, "R3 not yet ready");
        expect_at(5, 2, 32'h28, 32'h28, "R3 ready and R6 ok");
        step(6);

        pm_sleep_req = 1'b1;
        for (int d = 1; d <= 6; d++) expect_at(d, 2, 32'h18, 32'h08, "R4 sleep refused");
        step(7);

        write(1'b0, 32'h4);
        expect_at(1, 2, 32'h38, 32'h18, "R5 first sleep cycle R6 ok low");
        expect_at(3, 2, 32'h18, 32'h18, "R5 last sleep cycle");
        expect_at(4, 2, 32'h1F, 32'h01, "R5 asleep");
        step(5);

        pm_sleep_req = 1'b0;
        expect_at(4, 2, 32'h08, 32'h00, "R7 still waking");
        expect_at(5, 2, 32'h08, 32'h08, "R7 ready again");
        step(6);

        rf_kill_sw = 1'b1;
        expect_at(1, 2, 32'h0F, 32'h0A, "R11 radio mode");
        expect_at(1, 0, 32'h0F00_0000, 32'h0A00_0000, "R11 mode and rfkill fields");
        step(2);
        rf_kill_sw = 1'b0;
        expect_at(1, 2, 32'h07, 32'h00, "R11 mode none");
        step(2);

        write(1'b0, 32'hFFFF_FFFF);
        expect_at(1, 0, 32'hFFFF_FFFF, 32'h0000_040D, "R12 read-only bits");
        expect_at(1, 2, 32'h20, 32'h20, "R12 access ok");
        step(2);

        write(1'b0, 32'h0);
        expect_at(1, 2, 32'h0F, 32'h01, "R8 off after init clear");
        expect_at(1, 0, 32'hFFFF_FFFF, 32'h0100_0000, "R8 ctrl");
        step(2);

        write(1'b0, 32'h40C);
        step(6);
        write(1'b1, 32'h80);
        expect_at(1, 0, 32'hFFFF_FFFF, 32'h0100_0000, "R9 ctrl cleared");
        expect_at(1, 2, 32'h0F, 32'h01, "R9 off");
        expect_at(1, 1, 32'hFFFF_FFFF, 32'h0, "R9 soft bit reads 0");
        step(2);

        expect_at(1, 1, 32'hFFFF_FFFF, 32'h200, "R10 stop stored");
        expect_at(2, 1, 32'hFFFF_FFFF, 32'h300, "R10 disabled follows");
        write(1'b1, 32'h200);
        step(2);
        expect_at(1, 1, 32'hFFFF_FFFF, 32'h100, "R10 stop cleared");
        expect_at(2, 1, 32'hFFFF_FFFF, 32'h0, "R10 disabled cleared");
        write(1'b1, 32'h0);
        step(3);

        if (q.size() != 0) begin
            compared++; mismatched++;
            $display("FAIL R1 scoreboard: actual %0d pending expected 0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule